// File: doc/BRIEF.md
# Strobe Watchdog and Reset Sequencer

This block watches the two port strobe lines of a field-bus slave and turns several fault and command conditions into two classes of reset. A hard reset follows the supply comparators: it is raised whenever the logic supply is below its threshold. It is lowered only when both the logic supply and the field supply are reported good. While it is high, all of the block's own timers are cleared.

A soft reset is a one-cycle pulse. Three things raise it: a strobe-to-strobe idle timeout, an externally forced low on the data strobe that lasts too long, or a reset command flag from the protocol decoder. Each soft reset starts one fixed-length strobe request for both strobe drivers and tells the port drivers to let go of their outputs. The strobe it asks for appears on the sensed strobe lines like any other strobe, so it re-arms the idle timer.

All durations are counted in clock cycles and set by parameters. The defaults assume a 5.333333 MHz clock: the idle timeout is 75 ms, the long-low limit is 100 ms and the strobe is 6 µs.

Top module: `comm_supervisor`

## Requirements
- R1: Reset (`rst_n` low) puts `hard_rst` and `port_release` at 1 and `soft_rst` and `strobe_req` at 0. After reset, a clock edge that samples `v5_ok` = 0 sets `hard_rst` to 1 in that same cycle.
- R2: `hard_rst` falls only on an edge that samples both `v5_ok` = 1 and `v24_ok` = 1. While `v24_ok` is 0, it stays at 1.
- R3: Once `hard_rst` is 0, a low `v24_ok` alone does not raise it. A loss of strobes then ends in a soft reset by the idle timeout.
- R4: Strobe activity is the first edge that samples a strobe line low after it was sampled high, on either line. With `wd_enable` = 1 and no further activity, `soft_rst` rises exactly WD_TIMEOUT_CYC edges after the last activity edge. New activity on either line restarts the count.
- R5: The idle timer does not run before the first activity after a hard reset. It never fires while `wd_enable` = 0.
- R6: If `data_strobe_low` is sampled high on LONG_LOW_CYC-1 consecutive edges, no soft reset results. On the LONG_LOW_CYC-th consecutive edge, `soft_rst` rises. A single low period gives only one soft reset, however long it lasts.
- R7: `cmd_slave_reset` or `cmd_bcast_reset` sampled at 1 makes `soft_rst` high after that same edge.
- R8: Each soft reset is exactly one cycle of `soft_rst`. `strobe_req` rises with it and stays high for exactly STROBE_CYC cycles. Causes that coincide in one cycle still give one pulse.
- R9: `port_release` is 1 with every soft reset and from the cycle after `hard_rst` rises. It returns to 0 at the first strobe activity edge that falls while `strobe_req` is 0.
- R10: No soft reset is issued while `hard_rst` is 1, even when a command flag arrives.
- R11: The strobe requested by a soft reset, once looped back onto the strobe lines, re-arms the idle timer. With no other traffic, the next timeout soft reset comes WD_TIMEOUT_CYC+1 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_strobe_low | input | 1 | Data strobe line sensed low (1 = low) |
| param_strobe_low | input | 1 | Parameter strobe line sensed low (1 = low) |
| v5_ok | input | 1 | Logic supply above its threshold |
| v24_ok | input | 1 | Field supply above the communication threshold |
| cmd_slave_reset | input | 1 | One-cycle flag: addressed reset command received |
| cmd_bcast_reset | input | 1 | One-cycle flag: broadcast reset command received |
| wd_enable | input | 1 | Enables the strobe idle timer |
| hard_rst | output | 1 | Hard reset level |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| strobe_req | output | 1 | Request to pull both strobe lines low |
| port_release | output | 1 | Turn off all data and parameter port drivers |

## Verification
Two functions can fall in the same cycle: idle-timer expiry can coincide with either a command flag or fresh strobe activity. Both cases are set up by counting cycles from a strobe pulse. The command flag, or a one-cycle pulse on the other strobe line, is placed so that the block samples it on exactly the edge where the timer would expire. With a command, exactly one `soft_rst` cycle and one strobe of nominal length must result. With activity, no pulse may appear at that edge, and the timeout must move one full period later.

// File: rtl/comm_sup_pkg.sv
// Package: shared types for the strobe watchdog and reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package comm_sup_pkg;

    // Number of strobe lines watched for activity (data, parameter).
    localparam int unsigned NUM_STROBES = 2;

    // Collected causes that can raise a soft reset in one cycle.
    typedef struct packed {
        logic idle_timeout;
        logic long_low;
        logic command;
    } soft_cause_t;

endpackage

// File: rtl/sup_power_gate.sv
// Module: sup_power_gate
// Turns the two supply comparator flags into a hard reset level.
// Sets on a weak logic supply. Clears only when both supplies are good.
// Assumes: comparator flags are already synchronous to clk.
module sup_power_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic v5_ok,
    input  logic v24_ok,
    output logic hard_rst
);

    logic hard_q;

    // Hysteretic hard reset: raise on weak 5 V, release on both supplies good.
    always_ff @(posedge clk) begin
        if (!rst_n)          hard_q <= 1'b1;
        else if (!v5_ok)     hard_q <= 1'b1;
        else if (v24_ok)     hard_q <= 1'b0;
    end

    assign hard_rst = hard_q;

endmodule

// File: rtl/sup_idle_watchdog.sv
// Module: sup_idle_watchdog
// Strobe-to-strobe idle timer. It arms on the first activity and restarts
// on every later activity. It flags expiry after TIMEOUT_CYC quiet edges.
// Assumes: activity is a single-cycle event. Expiry disarms the timer.
module sup_idle_watchdog #(
    parameter int unsigned TIMEOUT_CYC = 400000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic activity,
    output logic expire
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;

    // Fresh activity always wins over an expiry in the same cycle.
    assign expire = enable && armed_q && (cnt_q == LAST) && !activity;

    // Idle counter: arm/restart on activity, count while armed, stop on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !enable) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (activity) begin
            armed_q <= 1'b1;
            cnt_q   <= '0;
        end else if (expire) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (armed_q) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sup_low_pulse_filter.sv
// Module: sup_low_pulse_filter
// Measures how long a strobe line is held low. It flags once when the
// low has been sampled on LIMIT_CYC consecutive edges.
// Assumes: the line must go high again before it can flag once more.
module sup_low_pulse_filter #(
    parameter int unsigned LIMIT_CYC = 533334
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic line_low,
    output logic long_low
);

    localparam int unsigned CW = $clog2(LIMIT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT_CYC - 1);

    logic          done_q;
    logic [CW-1:0] cnt_q;

    assign long_low = line_low && !done_q && (cnt_q == LAST);

    // Consecutive-low counter with one-shot latch per low period.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !line_low) begin
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else if (long_low) begin
            done_q <= 1'b1;
        end else if (!done_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sup_strobe_gen.sv
// Module: sup_strobe_gen
// Makes the fixed-length strobe request and the port release level
// that follow a soft reset. Release also holds through a hard reset.
// Assumes: trigger is a single-cycle cause already gated by hard reset.
module sup_strobe_gen #(
    parameter int unsigned STROBE_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hard,
    input  logic trigger,
    input  logic activity,
    output logic strobe_req,
    output logic port_release
);

    localparam int unsigned CW = $clog2(STROBE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(STROBE_CYC);

    logic [CW-1:0] cnt_q;
    logic          rel_q;

    // Strobe length counter: load on trigger, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n || hard)   cnt_q <= '0;
        else if (trigger)     cnt_q <= LOAD;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Port release: set by any reset, cleared by the next foreign strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || hard)                 rel_q <= 1'b1;
        else if (trigger)                   rel_q <= 1'b1;
        else if (activity && cnt_q == '0)   rel_q <= 1'b0;
    end

    assign strobe_req   = (cnt_q != '0);
    assign port_release = rel_q;

endmodule

// File: rtl/comm_supervisor.sv
// Module: comm_supervisor (top)
// Watches the strobe lines for activity. It combines the idle timer, the
// long-low filter and the command flags into a soft reset pulse. It sequences
// the resulting strobe and port release, and gates everything with the
// supply-driven hard reset.
// Assumes: all inputs are synchronous to clk; command flags last one cycle.
module comm_supervisor #(
    parameter int unsigned WD_TIMEOUT_CYC = 400000,
    parameter int unsigned LONG_LOW_CYC   = 533334,
    parameter int unsigned STROBE_CYC     = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_strobe_low,
    input  logic param_strobe_low,
    input  logic v5_ok,
    input  logic v24_ok,
    input  logic cmd_slave_reset,
    input  logic cmd_bcast_reset,
    input  logic wd_enable,
    output logic hard_rst,
    output logic soft_rst,
    output logic strobe_req,
    output logic port_release
);
    import comm_sup_pkg::*;

    logic [NUM_STROBES-1:0] line_low;
    logic [NUM_STROBES-1:0] line_act;
    logic                   any_act;
    logic                   hard_w;
    logic                   wd_expire;
    logic                   long_low;
    soft_cause_t            cause;
    logic                   trigger;
    logic                   soft_q;

    assign line_low = {param_strobe_low, data_strobe_low};

    // One falling-edge detector per strobe line.
    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_edge
        logic prev_q;
        // Remember last sampled level of this line.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= line_low[i];
        end
        assign line_act[i] = line_low[i] && !prev_q;
    end

    assign any_act = |line_act;

    sup_power_gate u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .v5_ok    (v5_ok),
        .v24_ok   (v24_ok),
        .hard_rst (hard_w)
    );

    sup_idle_watchdog #(.TIMEOUT_CYC(WD_TIMEOUT_CYC)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hard_w),
        .enable   (wd_enable),
        .activity (any_act),
        .expire   (wd_expire)
    );

    sup_low_pulse_filter #(.LIMIT_CYC(LONG_LOW_CYC)) u_lowpw (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hard_w),
        .line_low (data_strobe_low),
        .long_low (long_low)
    );

    assign cause.idle_timeout = wd_expire;
    assign cause.long_low     = long_low;
    assign cause.command      = cmd_slave_reset | cmd_bcast_reset;
    assign trigger            = !hard_w && (|cause);

    // Soft reset pulse register: one cycle per merged trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= trigger;
    end

    sup_strobe_gen #(.STROBE_CYC(STROBE_CYC)) u_stb (
        .clk          (clk),
        .rst_n        (rst_n),
        .hard         (hard_w),
        .trigger      (trigger),
        .activity     (any_act),
        .strobe_req   (strobe_req),
        .port_release (port_release)
    );

    assign hard_rst = hard_w;
    assign soft_rst = soft_q;

endmodule

// File: rtl/comm_supervisor_chk.sv
// Module: comm_supervisor_chk
// Temporal properties on the ports of comm_supervisor, attached by bind.
// Assumes: command flags are single-cycle, as the top module requires.
module comm_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic v5_ok,
    input logic v24_ok,
    input logic cmd_slave_reset,
    input logic cmd_bcast_reset,
    input logic hard_rst,
    input logic soft_rst,
    input logic strobe_req,
    input logic port_release
);

    assert_weak_supply_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !v5_ok |=> hard_rst);

    assert_hold_no_v24_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hard_rst && !v24_ok) |=> hard_rst);

    assert_v24_drop_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hard_rst && v5_ok) |=> !hard_rst);

    assert_cmd_soft_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_slave_reset || cmd_bcast_reset) && !hard_rst) |=> soft_rst);

    assert_soft_starts_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> strobe_req);

    assert_strobe_from_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_req) |-> soft_rst);

    assert_release_soft_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> port_release);

    assert_release_hard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> port_release);

    assert_no_soft_in_hard_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hard_rst |=> !soft_rst);

endmodule

bind comm_supervisor comm_supervisor_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .v5_ok           (v5_ok),
    .v24_ok          (v24_ok),
    .cmd_slave_reset (cmd_slave_reset),
    .cmd_bcast_reset (cmd_bcast_reset),
    .hard_rst        (hard_rst),
    .soft_rst        (soft_rst),
    .strobe_req      (strobe_req),
    .port_release    (port_release)
);

// File: tb/comm_supervisor_tb.sv
// Directed bench for comm_supervisor: one task per scenario.
// Inputs change and outputs are sampled on the falling clock edge.
module comm_supervisor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD  = 40;
    localparam int LL  = 60;
    localparam int STB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d_ext = 1'b0, p_ext = 1'b0;
    logic v5_ok = 1'b0, v24_ok = 1'b0;
    logic cmd_slave_reset = 1'b0, cmd_bcast_reset = 1'b0, wd_enable = 1'b0;
    logic hard_rst, soft_rst, strobe_req, port_release;
    logic data_strobe_low, param_strobe_low;

    int checks = 0;
    int failures = 0;
    int soft_seen = 0;
    bit finished = 1'b0;

    // Open-drain loopback: own strobe request pulls both lines low.
    assign data_strobe_low  = d_ext | strobe_req;
    assign param_strobe_low = p_ext | strobe_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    comm_supervisor #(
        .WD_TIMEOUT_CYC (WD),
        .LONG_LOW_CYC   (LL),
        .STROBE_CYC     (STB)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .data_strobe_low  (data_strobe_low),
        .param_strobe_low (param_strobe_low),
        .v5_ok            (v5_ok),
        .v24_ok           (v24_ok),
        .cmd_slave_reset  (cmd_slave_reset),
        .cmd_bcast_reset  (cmd_bcast_reset),
        .wd_enable        (wd_enable),
        .hard_rst         (hard_rst),
        .soft_rst         (soft_rst),
        .strobe_req       (strobe_req),
        .port_release     (port_release)
    );

    // Count cycles with soft reset high, as seen at the ports.
    always @(negedge clk) if (rst_n && soft_rst === 1'b1) soft_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_p();
        p_ext = 1'b1; cyc(1); p_ext = 1'b0;
    endtask

    // Count strobe_req cycles starting at the current (high) sample.
    task automatic count_strobe(input string req);
        int n = 0;
        for (int k = 0; k < 4 * STB && strobe_req; k++) begin
            n++;
            cyc(1);
        end
        chk(req, n, STB);
    endtask

    task automatic t_reset_and_power_up();
        cyc(3);
        chk("R1 hard in reset", hard_rst, 1);
        chk("R1 release in reset", port_release, 1);
        chk("R1 soft in reset", soft_rst, 0);
        chk("R1 strobe in reset", strobe_req, 0);
        rst_n = 1'b1; v5_ok = 1'b1;
        cyc(3);
        chk("R2 hold without v24", hard_rst, 1);
        v24_ok = 1'b1;
        cyc(1);
        chk("R2 release on both good", hard_rst, 0);
        chk("R9 release holds after hard", port_release, 1);
    endtask

    task automatic t_not_armed();
        int base;
        base = soft_seen;
        wd_enable = 1'b1;
        cyc(2 * WD);
        chk("R5 timer unarmed before strobe", soft_seen - base, 0);
        wd_enable = 1'b0;
        pulse_p();
        cyc(2 * WD);
        chk("R5 disabled timer silent", soft_seen - base, 0);
    endtask

    task automatic t_timeout_loop();
        wd_enable = 1'b1;
        pulse_p();
        cyc(WD - 1);
        chk("R4 no soft before timeout", soft_rst, 0);
        cyc(1);
        chk("R4 soft at timeout", soft_rst, 1);
        chk("R8 strobe with soft", strobe_req, 1);
        chk("R9 release with soft", port_release, 1);
        cyc(1);
        chk("R8 soft one cycle", soft_rst, 0);
        cyc(WD - 1);
        chk("R11 no early second soft", soft_rst, 0);
        cyc(1);
        chk("R11 own strobe re-armed timer", soft_rst, 1);
        wd_enable = 1'b0;
        count_strobe("R8 strobe length");
        cyc(2);
        chk("R9 release held after strobe", port_release, 1);
        d_ext = 1'b1; cyc(1); d_ext = 1'b0;
        chk("R9 release cleared by strobe", port_release, 0);
        cyc(3);
    endtask

    task automatic t_restart();
        wd_enable = 1'b1;
        pulse_p();
        cyc(19);
        d_ext = 1'b1; cyc(1); d_ext = 1'b0;
        cyc(WD - 20);
        chk("R4 restart moved timeout", soft_rst, 0);
        cyc(19);
        chk("R4 no soft before restarted timeout", soft_rst, 0);
        cyc(1);
        chk("R4 soft after restarted timeout", soft_rst, 1);
        wd_enable = 1'b0;
        cyc(STB + 3);
    endtask

    task automatic t_activity_vs_expiry();
        wd_enable = 1'b1;
        pulse_p();
        cyc(WD - 1);
        p_ext = 1'b1; cyc(1); p_ext = 1'b0;
        chk("R4 activity beats expiry", soft_rst, 0);
        cyc(WD - 1);
        chk("R4 no soft one before new timeout", soft_rst, 0);
        cyc(1);
        chk("R4 soft one period later", soft_rst, 1);
        wd_enable = 1'b0;
        cyc(STB + 3);
    endtask

    task automatic t_cmd_and_expiry();
        int base;
        wd_enable = 1'b1;
        pulse_p();
        base = soft_seen;
        cyc(WD - 1);
        cmd_slave_reset = 1'b1; cyc(1); cmd_slave_reset = 1'b0;
        wd_enable = 1'b0;
        chk("R7 command with expiry gives soft", soft_rst, 1);
        count_strobe("R8 merged strobe length");
        chk("R8 merged causes one pulse", soft_seen - base, 1);
        cyc(3);
    endtask

    task automatic t_bcast();
        cmd_bcast_reset = 1'b1; cyc(1); cmd_bcast_reset = 1'b0;
        chk("R7 broadcast command soft", soft_rst, 1);
        count_strobe("R8 broadcast strobe length");
        cyc(3);
    endtask

    task automatic t_low_pulses();
        int base;
        base = soft_seen;
        d_ext = 1'b1; cyc(LL - 1); d_ext = 1'b0;
        cyc(5);
        chk("R6 short low ignored", soft_seen - base, 0);
        base = soft_seen;
        d_ext = 1'b1;
        cyc(LL - 1);
        chk("R6 no soft one before limit", soft_rst, 0);
        cyc(1);
        chk("R6 soft at limit", soft_rst, 1);
        cyc(3 * LL);
        d_ext = 1'b0;
        cyc(STB + 3);
        chk("R6 one soft per low period", soft_seen - base, 1);
    endtask

    task automatic t_power_faults();
        int base;
        v24_ok = 1'b0;
        cyc(3);
        chk("R3 v24 drop keeps hard low", hard_rst, 0);
        wd_enable = 1'b1;
        pulse_p();
        cyc(WD);
        chk("R3 timeout gives soft on v24 loss", soft_rst, 1);
        chk("R3 no hard on v24 loss", hard_rst, 0);
        wd_enable = 1'b0;
        v24_ok = 1'b1;
        cyc(STB + 3);
        base = soft_seen;
        v5_ok = 1'b0;
        cyc(1);
        chk("R1 hard on weak 5V", hard_rst, 1);
        cmd_slave_reset = 1'b1; cyc(1); cmd_slave_reset = 1'b0;
        chk("R9 release during hard", port_release, 1);
        cyc(1);
        chk("R10 no soft in hard", soft_seen - base, 0);
        v5_ok = 1'b1;
        cyc(1);
        chk("R2 release after 5V back", hard_rst, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_and_power_up();
        t_not_armed();
        t_timeout_loop();
        t_restart();
        t_activity_vs_expiry();
        t_cmd_and_expiry();
        t_bcast();
        t_low_pulses();
        t_power_faults();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule